// File: doc/BRIEF.md
# Stepped Voltage Code Controller

This block turns a 3-bit voltage-select input into a 3-bit reference step index for an external DAC. Index 0 is the lowest output level and index 7 is the highest, with 50 mV between neighbouring levels. The select encoding is not monotonic: code 000 is a mid-range level. A select change is not applied at once. The block first waits for the select lines to stay quiet for a settle window. It then walks the index toward the new target one level per step interval. Because the reference moves in small steps, the output does not overshoot or undershoot.

Timing is counted in pulses of a one-cycle microsecond tick, so the settle window and the step interval are set as tick counts: 10 for the settle window and 5 for the step interval by default. A busy flag shows when a request is pending or in progress. The committed target index is also brought out. Driving the enable input low parks the index at the default level.

Top module: `vstep_ctrl`

## Requirements
- R1: The committed target index decodes the select code as follows: 000→3, 001→0, 010→1, 011→2, 100→4, 101→5, 110→6, 111→7.
- R2: While reset is high and after it is released, the index and target are 3 and busy is low. This holds for as long as the select stays 000.
- R3: After a select change, the index does not move until SETTLE_TICKS tick pulses have been counted with no further change.
- R4: Any select change during the settle window restarts the count from that change.
- R5: Once settled, the index moves by exactly one toward the target after every STEP_TICKS tick pulses. It stops on the target and never passes it.
- R6: Busy goes high on the clock edge that follows a select change. It stays high until the settle window has ended and the index equals the target.
- R7: With enable low, the index and target are forced to 3 and busy to 0, and the select input is ignored. When enable returns high, a select value other than 000 is treated as a new change.
- R8: A select change during slewing stops the stepping. After the new settle window, stepping resumes from the index reached so far.
- R9: Select bits that change at different cycles inside one settle window form a single request, decoded from their final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low parks the index at the default level |
| tick_us | input | 1 | One-cycle pulse, once per microsecond |
| vsel | input | 3 | Voltage select code |
| step_idx | output | 3 | Current reference step index to the DAC |
| busy | output | 1 | Request pending or index still moving |
| target_idx | output | 3 | Committed target index |

## Verification
The bench runs a behavioural model alongside the design and compares index, busy and target on every clock. Stimuli:

- **Upward jump from the default to the top code.** Shows settle gating apart from stepping.
- **Staggered bit changes across the settle window.** Show that a restart is not the same as an early commit.
- **Full descent to code 001.** Exposes the non-monotonic decode.
- **Retarget during a slew.** Shows whether stepping resumes from the current index or jumps.
- **Enable drop with a changing select.** Shows whether the disabled state really ignores the input.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    localparam int SEL_W = 3;
    localparam int IDX_W = 3;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam sel_t SEL_DEFAULT = '0;
    localparam idx_t IDX_MAX     = idx_t'((1 << IDX_W) - 1);

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    // request from the settle timer to the slew engine
    typedef struct packed {
        logic hold;    // settle window running or change seen this cycle
        logic load;    // settle window completes this cycle
        idx_t target;  // decoded index of the latched select
    } req_t;

    // non-monotonic decode: code 0 is mid-scale, codes 1..3 sit below it
    function automatic idx_t sel_to_idx(sel_t s);
        idx_t r;
        if (s == SEL_DEFAULT)
            r = idx_t'(3);
        else if (s[SEL_W-1])
            r = idx_t'(s);
        else
            r = idx_t'(s - sel_t'(1));
        return r;
    endfunction

    localparam idx_t IDX_DEFAULT = sel_to_idx(SEL_DEFAULT);

    function automatic dir_e step_dir(idx_t cur, idx_t tgt);
        dir_e d;
        if (tgt > cur)
            d = DIR_UP;
        else if (tgt < cur)
            d = DIR_DOWN;
        else
            d = DIR_HOLD;
        return d;
    endfunction

endpackage

// File: rtl/vstep_settle.sv
module vstep_settle
    import vstep_pkg::*;
#(
    parameter int SETTLE_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick_us,
    input  sel_t vsel,
    output req_t req,
    output logic settling,
    output logic changed
);

    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_TICKS - 1);

    sel_t          sel_q;
    logic [CW-1:0] cnt_q;
    logic          settling_q;

    assign changed  = (vsel != sel_q);
    assign settling = settling_q;

    always_comb begin
        req.hold   = settling_q | changed;
        req.load   = settling_q & ~changed & tick_us & (cnt_q == CNT_LAST);
        req.target = sel_to_idx(sel_q);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sel_q      <= SEL_DEFAULT;
            cnt_q      <= '0;
            settling_q <= 1'b0;
        end else if (changed) begin
            sel_q      <= vsel;
            cnt_q      <= '0;
            settling_q <= 1'b1;
        end else if (settling_q && tick_us) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q      <= '0;
                settling_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: a change always leaves a running window behind it
    a_r4_change_restarts: assert property (@(posedge clk) disable iff (rst)
        (en && changed) |=> (!en || settling_q));

endmodule

// File: rtl/vstep_slew.sv
module vstep_slew
    import vstep_pkg::*;
#(
    parameter int STEP_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick_us,
    input  req_t req,
    output idx_t idx,
    output idx_t tgt
);

    localparam int CW = $clog2(STEP_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STEP_TICKS - 1);

    idx_t          idx_q;
    idx_t          tgt_q;
    logic [CW-1:0] scnt_q;
    dir_e          dir;
    idx_t          idx_next;

    assign dir = step_dir(idx_q, tgt_q);

    always_comb begin
        case (dir)
            DIR_UP:   idx_next = idx_q + idx_t'(1);
            DIR_DOWN: idx_next = idx_q - idx_t'(1);
            default:  idx_next = idx_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx_q  <= IDX_DEFAULT;
            tgt_q  <= IDX_DEFAULT;
            scnt_q <= '0;
        end else begin
            if (req.load)
                tgt_q <= req.target;
            if (req.hold || dir == DIR_HOLD) begin
                scnt_q <= '0;
            end else if (tick_us) begin
                if (scnt_q == CNT_LAST) begin
                    scnt_q <= '0;
                    idx_q  <= idx_next;
                end else begin
                    scnt_q <= scnt_q + 1'b1;
                end
            end
        end
    end

    assign idx = idx_q;
    assign tgt = tgt_q;

    // R5: at most one level per move
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |->
            ((int'(idx_q) == int'($past(idx_q))) ||
             (int'(idx_q) == int'($past(idx_q)) + 1) ||
             (int'(idx_q) + 1 == int'($past(idx_q)))));

    // R5: a move never passes the target it was heading for
    a_r5_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (idx_q != $past(idx_q))) |->
            (((idx_q > $past(idx_q)) && (idx_q <= $past(tgt_q))) ||
             ((idx_q < $past(idx_q)) && (idx_q >= $past(tgt_q)))));

    // R3: no movement while the settle window holds the engine
    a_r3_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (en && req.hold) |=> (!en || $stable(idx_q)));

endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
    import vstep_pkg::*;
#(
    parameter int SETTLE_TICKS = 10,
    parameter int STEP_TICKS   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick_us,
    input  logic [SEL_W-1:0] vsel,
    output logic [IDX_W-1:0] step_idx,
    output logic             busy,
    output logic [IDX_W-1:0] target_idx
);

    req_t req;
    logic settling;
    logic changed;
    idx_t idx;
    idx_t tgt;

    vstep_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick_us  (tick_us),
        .vsel     (vsel),
        .req      (req),
        .settling (settling),
        .changed  (changed)
    );

    vstep_slew #(.STEP_TICKS(STEP_TICKS)) u_slew (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick_us (tick_us),
        .req     (req),
        .idx     (idx),
        .tgt     (tgt)
    );

    assign step_idx   = idx;
    assign target_idx = tgt;
    assign busy       = settling | (idx != tgt);

    // R7: disabled state parks everything at the default level
    a_r7_disabled_parks: assert property (@(posedge clk) disable iff (rst)
        !en |=> (step_idx == IDX_DEFAULT && target_idx == IDX_DEFAULT && !busy));

    // R6: a change is reported as busy on the next cycle
    a_r6_busy_after_change: assert property (@(posedge clk) disable iff (rst)
        (en && changed) |=> (!en || busy));

endmodule

// File: tb/sim_vstep_ctrl.sv
module sim_vstep_ctrl;

    localparam int SET_T  = 10;
    localparam int STEP_T = 5;
    localparam int TDIV   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       tick_us = 1'b0;
    logic [2:0] vsel = 3'b000;
    logic [2:0] step_idx;
    logic       busy;
    logic [2:0] target_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tdiv = 0;

    always #4 clk = ~clk;   // 8 ns period

    vstep_ctrl #(.SETTLE_TICKS(SET_T), .STEP_TICKS(STEP_T)) u0 (
        .clk(clk), .rst(rst), .en(en), .tick_us(tick_us), .vsel(vsel),
        .step_idx(step_idx), .busy(busy), .target_idx(target_idx)
    );

    function automatic int lvl(logic [2:0] s);
        case (s)
            3'b000: return 3;
            3'b001: return 0;
            3'b010: return 1;
            3'b011: return 2;
            3'b100: return 4;
            3'b101: return 5;
            3'b110: return 6;
            default: return 7;
        endcase
    endfunction

    // behavioural reference model
    int m_idx = 3, m_tgt = 3, m_wait = 0, m_acc = 0;
    logic [2:0] m_last = 3'b000;

    always @(posedge clk) begin
        if (rst || !en) begin
            m_idx = 3; m_tgt = 3; m_wait = 0; m_acc = 0; m_last = 3'b000;
        end else if (vsel != m_last) begin
            m_last = vsel; m_wait = SET_T; m_acc = 0;
        end else if (m_wait > 0) begin
            m_acc = 0;
            if (tick_us) begin
                m_wait = m_wait - 1;
                if (m_wait == 0) m_tgt = lvl(m_last);
            end
        end else if (m_idx != m_tgt) begin
            if (tick_us) begin
                m_acc = m_acc + 1;
                if (m_acc == STEP_T) begin
                    m_acc = 0;
                    m_idx = (m_tgt > m_idx) ? m_idx + 1 : m_idx - 1;
                end
            end
        end else begin
            m_acc = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(int'(step_idx) == m_idx, "R5 index", int'(step_idx), m_idx);
            chk(int'(target_idx) == m_tgt, "R1 target", int'(target_idx), m_tgt);
            chk(busy == ((m_wait > 0) || (m_idx != m_tgt)), "R6 busy",
                int'(busy), int'((m_wait > 0) || (m_idx != m_tgt)));
        end
        tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick_us = (tdiv == 0);
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // R2: reset state
        chk(step_idx == 3'd3, "R2 reset index", int'(step_idx), 3);
        chk(target_idx == 3'd3, "R2 reset target", int'(target_idx), 3);
        chk(!busy, "R2 reset busy", int'(busy), 0);

        // R3/R6: upward jump, gated by settle window
        vsel = 3'b111;
        wait_cyc(30);
        chk(step_idx == 3'd3, "R3 held during settle", int'(step_idx), 3);
        chk(busy, "R6 busy during settle", int'(busy), 1);
        wait_idle();
        chk(step_idx == 3'd7, "R5 reached top", int'(step_idx), 7);
        chk(target_idx == 3'd7, "R1 code 111", int'(target_idx), 7);

        // R4/R9: staggered bits, each restarting the window
        vsel = 3'b101;
        wait_cyc(12);
        vsel = 3'b100;
        wait_cyc(12);
        vsel = 3'b001;
        wait_cyc(35);
        chk(step_idx == 3'd7, "R4 restart holds index", int'(step_idx), 7);
        chk(target_idx == 3'd7, "R9 no early commit", int'(target_idx), 7);
        wait_idle();
        chk(step_idx == 3'd0, "R9 final code 001", int'(step_idx), 0);
        chk(target_idx == 3'd0, "R1 code 001", int'(target_idx), 0);

        // R8: retarget mid-slew, resumes from current index
        vsel = 3'b110;
        wait_cyc(40 + 20 * 2 + 6);
        vsel = 3'b010;
        wait_cyc(20);
        chk(step_idx == 3'd2, "R8 frozen mid slew", int'(step_idx), 2);
        wait_idle();
        chk(step_idx == 3'd1, "R8 final code 010", int'(step_idx), 1);

        vsel = 3'b011;
        wait_idle();
        chk(target_idx == 3'd2, "R1 code 011", int'(target_idx), 2);
        vsel = 3'b000;
        wait_idle();
        chk(step_idx == 3'd3, "R1 code 000", int'(step_idx), 3);

        // R7: enable low ignores select
        vsel = 3'b110;
        wait_cyc(50);
        en = 1'b0;
        wait_cyc(2);
        vsel = 3'b101;
        wait_cyc(60);
        chk(step_idx == 3'd3, "R7 parked index", int'(step_idx), 3);
        chk(!busy, "R7 parked busy", int'(busy), 0);
        chk(target_idx == 3'd3, "R7 parked target", int'(target_idx), 3);
        en = 1'b1;
        wait_cyc(2);
        chk(busy, "R7 re-enable sees change", int'(busy), 1);
        wait_idle();
        chk(step_idx == 3'd5, "R7 code 101 after enable", int'(step_idx), 5);
        vsel = 3'b100;
        wait_idle();
        chk(step_idx == 3'd4, "R1 code 100", int'(step_idx), 4);

        wait_cyc(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule